// File: doc/BRIEF.md
# Write-Only Serial Control Register Port

This block receives configuration for a stereo audio datapath over three wires: a control clock, a serial data line and a latch strobe. Words of 16 bits arrive most significant bit first and collect in a shift register; nothing reaches the outputs until the latch strobe rises. At that moment the collected word is decoded into global fields and one channel's volume request. The global fields are the serial input format, de-emphasis enable, soft power-down and mute. The channel-select bit picks the left or right volume register.

All three wires are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are found in the system clock domain. The reset values give full volume, no mute, no power-down and the first input format, so a datapath can run with the port left idle. While soft power-down is set, or during hardware reset, a clear output tells the datapath to zero its state. There is no readback.

Top module: `wo_ctl_port`

## Requirements
- R1: While `rst` is high and after it is released, the outputs hold their defaults until the first latch. The defaults are `fmt_o`=0, `pwr_down_o`=0, `deemph_o`=0, `mute_o`=0, and both `vol_left_o` and `vol_right_o` at 0x3FF.
- R2: A data bit is taken on each rising edge of the control clock. Each new bit enters at the least significant end of a 16-bit shift register, so the first bit sent ends up as bit 15.
- R3: The outputs change only when the latch strobe rises. Clock edges and data without a latch rise leave every output unchanged.
- R4: At the latch rise, word bits [15:14] drive `fmt_o` (0 right-justified 16-bit, 1 I2S, 2 left-justified, 3 DSP-style frame). Bit 13 drives `pwr_down_o`, bit 12 drives `deemph_o` and bit 11 drives `mute_o` (1 = muted).
- R5: Word bit 10 selects the channel: 0 loads bits [9:0] into `vol_left_o`, and 1 loads them into `vol_right_o`. The other channel's volume keeps its value.
- R6: Format, power-down, de-emphasis and mute are global. Every latched write updates them, whichever channel it addresses.
- R7: If more than 16 control clock edges come before a latch, only the last 16 bits shifted in are committed.
- R8: `dp_clear_o` is high while soft power-down is set and in the cycles after `rst` is sampled high. It is low otherwise.
- R9: If a latch rise and a control clock rise are detected in the same system cycle, the latch commits the word as it stood before that clock edge. The new bit is still shifted in, and a later latch commits it.
- R10: A committed write appears on the outputs within four system clock cycles of the latch strobe rising at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; restores defaults |
| ctl_clk_i | input | 1 | Asynchronous control clock; data is taken on its rising edge |
| ctl_dat_i | input | 1 | Serial control data, MSB first |
| ctl_lat_i | input | 1 | Latch strobe; rising edge commits the word |
| fmt_o | output | 2 | Serial input format select |
| pwr_down_o | output | 1 | Soft power-down request |
| deemph_o | output | 1 | De-emphasis enable |
| mute_o | output | 1 | Mute for both channels |
| vol_left_o | output | 10 | Left channel volume request |
| vol_right_o | output | 10 | Right channel volume request |
| dp_clear_o | output | 1 | Datapath clear (reset or soft power-down) |

## Verification
Shifting a data bit and committing the word can fall in the same system cycle. Both detectors see a rising edge on the same cycle when the control clock and the latch strobe are raised on the same system clock phase. The bench does exactly that on a known shift-register content. It expects the commit to carry the word from before the edge. A second latch with no clock edges between must then carry that word shifted left by one bit, with the new bit at the bottom. A hardware reset in the middle of traffic is the second overlap, and the bench judges it against the defaults.

// File: rtl/wo_ctl_pkg.sv
package wo_ctl_pkg;

    localparam int WORD_W     = 16;
    localparam int VOL_W      = 10;
    localparam int FMT_HI_BIT = 15;
    localparam int PD_BIT     = 13;
    localparam int DEEMPH_BIT = 12;
    localparam int MUTE_BIT   = 11;
    localparam int CHAN_BIT   = 10;

    typedef enum logic [1:0] {
        FMT_RJ16 = 2'd0,
        FMT_I2S  = 2'd1,
        FMT_LJ   = 2'd2,
        FMT_DSP  = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic pwr_down;
        logic deemph;
        logic mute;
    } glob_t;

    localparam glob_t GLOB_DEFAULT = '{fmt: FMT_RJ16, pwr_down: 1'b0,
                                       deemph: 1'b0, mute: 1'b0};

    function automatic glob_t decode_glob(input logic [WORD_W-1:0] w);
        glob_t g;
        g.fmt      = fmt_e'(w[FMT_HI_BIT -: 2]);
        g.pwr_down = w[PD_BIT];
        g.deemph   = w[DEEMPH_BIT];
        g.mute     = w[MUTE_BIT];
        return g;
    endfunction

endpackage

// File: rtl/wo_ctl_sync.sv
module wo_ctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wo_ctl_shift.sv
module wo_ctl_shift
    import wo_ctl_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk_s,
    input  logic          sdat_s,
    input  logic          slat_s,
    output logic [WW-1:0] word_o,
    output logic          commit_o
);
    logic          sclk_q, slat_q;
    logic          clk_rise;
    logic [WW-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            slat_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            slat_q <= slat_s;
        end
    end

    assign clk_rise = sclk_s & ~sclk_q;
    assign commit_o = slat_s & ~slat_q;

    // R2 / R7: the register keeps only the newest WW bits
    always_ff @(posedge clk) begin
        if (rst)           shift_q <= '0;
        else if (clk_rise) shift_q <= {shift_q[WW-2:0], sdat_s};
    end

    // R9: the commit sees the pre-edge contents
    assign word_o = shift_q;

    a_r2_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
        !clk_rise |=> $stable(shift_q));

    a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
        clk_rise |=> !clk_rise);

    a_r3_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);
endmodule

// File: rtl/wo_ctl_regs.sv
module wo_ctl_regs
    import wo_ctl_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int VW = VOL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_i,
    input  logic [WW-1:0] word_i,
    output glob_t         glob_o,
    output logic [VW-1:0] vol_l_o,
    output logic [VW-1:0] vol_r_o,
    output logic          dp_clear_o
);
    localparam logic [VW-1:0] VOL_DEFAULT = '1;

    logic rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_o  <= GLOB_DEFAULT;
            vol_l_o <= VOL_DEFAULT;
            vol_r_o <= VOL_DEFAULT;
        end else if (commit_i) begin
            glob_o <= decode_glob(word_i);
            if (word_i[CHAN_BIT]) vol_r_o <= word_i[VW-1:0];
            else                  vol_l_o <= word_i[VW-1:0];
        end
    end

    always_ff @(posedge clk) rst_q <= rst;

    assign dp_clear_o = rst_q | glob_o.pwr_down;

    a_r1_defaults: assert property (@(posedge clk)
        rst |=> (vol_l_o == VOL_DEFAULT) && (vol_r_o == VOL_DEFAULT)
                && (glob_o == GLOB_DEFAULT));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(glob_o) && $stable(vol_l_o) && $stable(vol_r_o));

    a_r5_right_keeps_left: assert property (@(posedge clk) disable iff (rst)
        commit_i && word_i[CHAN_BIT] |=> $stable(vol_l_o));

    a_r5_left_keeps_right: assert property (@(posedge clk) disable iff (rst)
        commit_i && !word_i[CHAN_BIT] |=> $stable(vol_r_o));
endmodule

// File: rtl/wo_ctl_port.sv
module wo_ctl_port
    import wo_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_clk_i,
    input  logic             ctl_dat_i,
    input  logic             ctl_lat_i,
    output logic [1:0]       fmt_o,
    output logic             pwr_down_o,
    output logic             deemph_o,
    output logic             mute_o,
    output logic [VOL_W-1:0] vol_left_o,
    output logic [VOL_W-1:0] vol_right_o,
    output logic             dp_clear_o
);
    logic [2:0]        pins_s;
    logic              commit;
    logic [WORD_W-1:0] word;
    glob_t             glob;

    wo_ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ctl_lat_i, ctl_dat_i, ctl_clk_i}),
        .q   (pins_s)
    );

    wo_ctl_shift #(.WW(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (pins_s[0]),
        .sdat_s   (pins_s[1]),
        .slat_s   (pins_s[2]),
        .word_o   (word),
        .commit_o (commit)
    );

    wo_ctl_regs #(.WW(WORD_W), .VW(VOL_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .commit_i   (commit),
        .word_i     (word),
        .glob_o     (glob),
        .vol_l_o    (vol_left_o),
        .vol_r_o    (vol_right_o),
        .dp_clear_o (dp_clear_o)
    );

    assign fmt_o      = glob.fmt;
    assign pwr_down_o = glob.pwr_down;
    assign deemph_o   = glob.deemph;
    assign mute_o     = glob.mute;

    a_r8_clear_follows_pd: assert property (@(posedge clk) disable iff (rst)
        pwr_down_o |-> dp_clear_o);
endmodule

// File: tb/wo_ctl_port_tb_top.sv
module wo_ctl_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_clk = 1'b0, ctl_dat = 1'b0, ctl_lat = 1'b0;
    logic [1:0] fmt;
    logic       pwr_down, deemph, mute, dp_clear;
    logic [9:0] vol_l, vol_r;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        logic [1:0] fmt;
        logic       pd, de, mu;
        logic [9:0] vl, vr;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [1:0] m_fmt;
    logic       m_pd, m_de, m_mu;
    logic [9:0] m_vl, m_vr;
    logic [15:0] m_shift;

    always #5 clk = ~clk;

    wo_ctl_port dut_i (
        .clk(clk), .rst(rst),
        .ctl_clk_i(ctl_clk), .ctl_dat_i(ctl_dat), .ctl_lat_i(ctl_lat),
        .fmt_o(fmt), .pwr_down_o(pwr_down), .deemph_o(deemph), .mute_o(mute),
        .vol_left_o(vol_l), .vol_right_o(vol_r), .dp_clear_o(dp_clear)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_defaults();
        m_fmt = 2'd0; m_pd = 0; m_de = 0; m_mu = 0;
        m_vl = 10'h3FF; m_vr = 10'h3FF; m_shift = '0;
    endtask

    function automatic exp_t snap(input string tag);
        exp_t e;
        e.fmt = m_fmt; e.pd = m_pd; e.de = m_de; e.mu = m_mu;
        e.vl = m_vl; e.vr = m_vr; e.tag = tag;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        chk({e.tag, " fmt"},   {30'd0, fmt},   {30'd0, e.fmt});
        chk({e.tag, " pd"},    {31'd0, pwr_down}, {31'd0, e.pd});
        chk({e.tag, " deemph"},{31'd0, deemph}, {31'd0, e.de});
        chk({e.tag, " mute"},  {31'd0, mute},  {31'd0, e.mu});
        chk({e.tag, " vol_l"}, {22'd0, vol_l}, {22'd0, e.vl});
        chk({e.tag, " vol_r"}, {22'd0, vol_r}, {22'd0, e.vr});
    endtask

    // commit the model shift register, as the R4/R5/R6 decode defines
    task automatic model_commit(input string tag);
        m_fmt = m_shift[15:14];
        m_pd  = m_shift[13];
        m_de  = m_shift[12];
        m_mu  = m_shift[11];
        if (m_shift[10]) m_vr = m_shift[9:0];
        else             m_vl = m_shift[9:0];
        sb_q.push_back(snap(tag));
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ctl_dat = bits[i];
            ctl_clk = 1'b0;
            repeat (3) @(negedge clk);
            ctl_clk = 1'b1;
            m_shift = {m_shift[14:0], bits[i]};
            repeat (3) @(negedge clk);
        end
        ctl_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic latch(input string tag);
        model_commit(tag);
        ctl_lat = 1'b1;
        repeat (6) @(negedge clk);
        ctl_lat = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops one expectation per latch rise, R10 latency window
    initial begin
        forever begin
            @(posedge ctl_lat);
            repeat (4) @(negedge clk);
            if (sb_q.size() == 0) begin
                chk("R10 scoreboard underflow", 32'd1, 32'd0);
            end else begin
                compare(sb_q.pop_front());
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_defaults();
        repeat (4) @(negedge clk);
        chk("R8 clear during reset", {31'd0, dp_clear}, 32'd1);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        compare(snap("R1 defaults"));
        chk("R8 clear after reset", {31'd0, dp_clear}, 32'd0);

        // R2 R4 R5: left write, format LJ, de-emphasis on
        send_bits({16'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 10'h155}, 16);
        latch("R4 left write");

        // R5 R6: right write changes global fields, left keeps 0x155
        send_bits({16'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 10'h0AA}, 16);
        latch("R6 right write");

        // R8: soft power-down raises the clear
        send_bits({16'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000}, 16);
        latch("R8 soft pd write");
        chk("R8 clear with pd", {31'd0, dp_clear}, 32'd1);

        send_bits({16'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 10'h201}, 16);
        latch("R5 right pd off");
        chk("R8 clear released", {31'd0, dp_clear}, 32'd0);

        // R3: full word without latch has no effect
        send_bits({16'd0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 10'h0F0}, 16);
        repeat (10) @(negedge clk);
        compare(snap("R3 no latch"));
        latch("R3 late latch");

        // R7: 20 bits, only the last 16 (0x1234) count
        send_bits(32'h000F_1234, 20);
        latch("R7 overlength");
        chk("R7 vol_l value", {22'd0, vol_l}, 32'h234);

        // R9: latch and clock rise together
        send_bits({16'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 10'h0C3}, 16);
        ctl_dat = 1'b1;
        repeat (3) @(negedge clk);
        model_commit("R9 same cycle");
        ctl_clk = 1'b1;
        ctl_lat = 1'b1;
        m_shift = {m_shift[14:0], 1'b1};
        repeat (6) @(negedge clk);
        ctl_clk = 1'b0;
        ctl_lat = 1'b0;
        repeat (3) @(negedge clk);
        latch("R9 shifted follow-up");

        // R1: hardware reset in the middle of traffic
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        model_defaults();
        repeat (3) @(negedge clk);
        compare(snap("R1 after mid reset"));

        repeat (5) @(negedge clk);
        chk("R10 scoreboard drained", sb_q.size(), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule